// File: doc/BRIEF.md
# Chained Debug Event Counter Pair

This block holds two down-counters that tally processor debug events and signal a debug event when a counter runs out. Each counter watches the same set of single-cycle event strobes through its own enable mask. The events are four instruction-address matches, read and write matches on two data addresses, two external debug inputs, instruction completion, interrupt entry and interrupt return. A counter moves down by one in any cycle in which at least one of its enabled events strobes. When it steps from one to zero it produces a one-cycle zero pulse. It then rests at zero until software loads a new value.

Counter 1 can be held idle until an arming trigger occurs. The trigger set is a few of the event strobes plus the zero pulse of counter 2, so counter 2 can gate counter 1. Address-match events raised during a multi-word load or store are merged into one count when the access completes. They are dropped if an interrupt aborts the access. Software configures the block through a small register write port. Each zero pulse reaches its debug output only when that counter's exception enable is set, but the counters run either way.

Top module: `dbg_evt_ctr_pair`

## Requirements
- R1: After reset both counters read 0, all event masks, the trigger mask and both exception enables are 0, counter 1 is not armed, and no debug output is high.
- R2: A write loads the register at its address: 0 is the counter 1 event mask, 1 is the counter 2 event mask, 2 holds the trigger mask in data bits 6:0 with exception enables in bit 8 (counter 1) and bit 9 (counter 2), 3 loads counter 1 and 4 loads counter 2 from data bits 15:0. A load takes precedence over a decrement in the same cycle.
- R3: Event bits are 0–3 instruction-address matches 1–4, 4 data 1 read, 5 data 1 write, 6 data 2 read, 7 data 2 write, 8 external 1, 9 external 2, 10 instruction complete, 11 interrupt taken, 12 return. The same bit positions are used in the masks. A nonzero running counter drops by exactly one in the cycle after a cycle that has one or more enabled events, however many there are.
- R4: Event strobes whose mask bit is clear leave the counter unchanged.
- R5: A step from 1 to 0 produces a zero pulse lasting one cycle. It is seen in the same cycle as the 0 count. A counter at 0 stays at 0 on further events.
- R6: A debug output rises only for a zero pulse of its counter while that counter's exception enable is set. The counters decrement whether or not the enable is set.
- R7: Trigger bits are 0 external 1, 1 external 2, 2 address match 1, 3 address match 3, 4 data 1 read, 5 data 1 write, 6 counter 2 zero. While the trigger mask is nonzero and counter 1 is unarmed, counter 1 ignores events. An enabled trigger arms it from the next cycle on, and the triggering cycle is not counted.
- R8: The counter 2 zero pulse arms counter 1 when trigger bit 6 is set, even while the counter 2 exception enable is clear.
- R9: Once armed, counter 1 stays armed until a write to address 2, which disarms it.
- R10: While a multi-word access is active, enabled address-match events (bits 0–7) cause at most one decrement, taken in the cycle the access completes.
- R11: A multi-word access aborted by an interrupt contributes no count from its address-match events.
- R12: Enabled events other than address matches count normally during a multi-word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| evt | input | 13 | Debug event strobes, one cycle each |
| mw_active | input | 1 | Multi-word access in progress |
| mw_done | input | 1 | Multi-word access completes this cycle |
| mw_abort | input | 1 | Multi-word access aborted by interrupt this cycle |
| cnt1_o | output | 16 | Counter 1 value |
| cnt2_o | output | 16 | Counter 2 value |
| c1_armed_o | output | 1 | Counter 1 armed |
| dbg_evt1_o | output | 1 | Counter 1 debug event pulse |
| dbg_evt2_o | output | 1 | Counter 2 debug event pulse |

## Verification
The chained arming path is the hardest case to reach from the ports. Counter 2 must run out first, its zero pulse then has to arm counter 1 one cycle later, and all of this happens with the counter 2 debug output held low. The stimulus loads counter 2 with one, enables only the chain trigger, and shows that counter 1 ignores events before the pulse. It then steps counter 2 to zero and shows counter 1 counting from the second cycle after. The multi-word cases are driven as bursts of address matches under the active qualifier, ended by either a completion or an abort strobe.

// File: rtl/dbg_evt_pkg.sv
// Shared constants for the debug event counter pair.
// Assumes event strobes and masks share one bit layout.
package dbg_evt_pkg;
    localparam int NUM_EVT  = 13;
    localparam int NUM_TRIG = 7;
    localparam int ADDR_W   = 3;

    localparam int EV_IAC1 = 0;
    localparam int EV_IAC3 = 2;
    localparam int EV_D1R  = 4;
    localparam int EV_D1W  = 5;
    localparam int EV_EXT1 = 8;
    localparam int EV_EXT2 = 9;

    // Address-match events (instruction and data compares) are merged during multi-word accesses
    localparam logic [NUM_EVT-1:0] ADDR_EVT_SEL = 13'h00FF;

    localparam int XEN1_BIT = 8;
    localparam int XEN2_BIT = 9;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK1 = 3'd0,
        RA_MASK2 = 3'd1,
        RA_TRIG  = 3'd2,
        RA_CNT1  = 3'd3,
        RA_CNT2  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/dbg_ctr_unit.sv
// One debug event down-counter.
// Decrements once per cycle with any enabled event while run is high and
// the count is nonzero. Address-match events seen inside a multi-word access
// are held in a pending flag and counted once on completion, or dropped on abort.
// Assumes mw_done and mw_abort are never high together.
module dbg_ctr_unit #(
    parameter int CNT_W = 16,
    parameter int NEV   = 13,
    parameter logic [NEV-1:0] ADDR_SEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEV-1:0]   evt,
    input  logic [NEV-1:0]   mask,
    input  logic             run,
    input  logic             mw_active,
    input  logic             mw_done,
    input  logic             mw_abort,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_pulse
);
    logic addr_hit, other_hit, mw_end, in_mw, addr_take, step, pend;

    // Classify enabled events and decide whether this cycle steps
    always_comb begin
        addr_hit  = |(evt & mask & ADDR_SEL);
        other_hit = |(evt & mask & ~ADDR_SEL);
        mw_end    = mw_done | mw_abort;
        in_mw     = mw_active | mw_end;
        addr_take = in_mw ? (mw_done & (pend | addr_hit)) : addr_hit;
        step      = run & (other_hit | addr_take) & (count != '0);
    end

    // Pending address-match flag for the current multi-word access
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend <= 1'b0;
        else if (mw_end)                     pend <= 1'b0;
        else if (mw_active && run && addr_hit) pend <= 1'b1;
    end

    // Count register and registered one-to-zero pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= !load && step && (count == CNT_W'(1));
            if (load)      count <= load_val;
            else if (step) count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dbg_arm_unit.sv
// Arming latch for counter 1.
// With an empty trigger mask the counter always runs; otherwise it runs
// only after an enabled trigger has been seen. A config clear disarms it.
module dbg_arm_unit #(
    parameter int NTRIG = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_src,
    input  logic [NTRIG-1:0] trig_mask,
    input  logic             clear,
    output logic             armed,
    output logic             run
);
    // Run gate: free-running when no trigger is enabled
    always_comb run = (trig_mask == '0) | armed;

    // Sticky arm flag
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (clear) armed <= 1'b0;
        else if (|(trig_src & trig_mask)) armed <= 1'b1;
    end
endmodule

// File: rtl/dbg_evt_ctr_pair.sv
// Chained pair of debug event down-counters with register write port.
// Counter index 0 is counter 1 (armable), index 1 is counter 2 (always runs).
// Assumes DATA_W covers the widest register field.
module dbg_evt_ctr_pair
    import dbg_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_EVT-1:0]  evt,
    input  logic                mw_active,
    input  logic                mw_done,
    input  logic                mw_abort,
    output logic [CNT_W-1:0]    cnt1_o,
    output logic [CNT_W-1:0]    cnt2_o,
    output logic                c1_armed_o,
    output logic                dbg_evt1_o,
    output logic                dbg_evt2_o
);
    localparam int NCTR = 2;

    logic [NUM_EVT-1:0]  evt_mask [NCTR];
    logic [NUM_TRIG-1:0] trig_mask;
    logic [NCTR-1:0]     exc_en;
    logic [NCTR-1:0]     run_v, load_v, zero_v;
    logic [CNT_W-1:0]    cnt_v [NCTR];
    logic [NUM_TRIG-1:0] trig_src;
    logic                trig_wr;

    always_comb trig_wr = wr_en && (wr_addr == RA_TRIG);

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_mask[0] <= '0;
            evt_mask[1] <= '0;
            trig_mask   <= '0;
            exc_en      <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_MASK1) evt_mask[0] <= wr_data[NUM_EVT-1:0];
            if (wr_addr == RA_MASK2) evt_mask[1] <= wr_data[NUM_EVT-1:0];
            if (wr_addr == RA_TRIG) begin
                trig_mask <= wr_data[NUM_TRIG-1:0];
                exc_en    <= {wr_data[XEN2_BIT], wr_data[XEN1_BIT]};
            end
        end
    end

    // Trigger sources in trigger-mask bit order
    always_comb trig_src = {zero_v[1], evt[EV_D1W], evt[EV_D1R], evt[EV_IAC3],
                            evt[EV_IAC1], evt[EV_EXT2], evt[EV_EXT1]};

    dbg_arm_unit #(.NTRIG(NUM_TRIG)) u_arm (
        .clk(clk), .rst_n(rst_n), .trig_src(trig_src), .trig_mask(trig_mask),
        .clear(trig_wr), .armed(c1_armed_o), .run(run_v[0])
    );

    always_comb run_v[1] = 1'b1;

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        // Load strobe for this counter's value register
        always_comb load_v[i] = wr_en && (wr_addr == ADDR_W'(int'(RA_CNT1) + i));

        dbg_ctr_unit #(.CNT_W(CNT_W), .NEV(NUM_EVT), .ADDR_SEL(ADDR_EVT_SEL)) u_ctr (
            .clk(clk), .rst_n(rst_n), .evt(evt), .mask(evt_mask[i]), .run(run_v[i]),
            .mw_active(mw_active), .mw_done(mw_done), .mw_abort(mw_abort),
            .load(load_v[i]), .load_val(wr_data[CNT_W-1:0]),
            .count(cnt_v[i]), .zero_pulse(zero_v[i])
        );
    end

    // Outputs: debug pulses gated by exception enables
    always_comb begin
        cnt1_o     = cnt_v[0];
        cnt2_o     = cnt_v[1];
        dbg_evt1_o = zero_v[0] & exc_en[0];
        dbg_evt2_o = zero_v[1] & exc_en[1];
    end
endmodule

// File: rtl/dbg_evt_ctr_pair_chk.sv
// Property checker for the counter pair, bound to the top module.
module dbg_evt_ctr_pair_chk
    import dbg_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  cnt1_o,
    input logic [CNT_W-1:0]  cnt2_o,
    input logic              c1_armed_o,
    input logic              dbg_evt1_o,
    input logic              dbg_evt2_o,
    input logic [1:0]        exc_en,
    input logic [NUM_TRIG-1:0] trig_mask
);
    assert_pulse_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt1_o |-> cnt1_o == '0);
    assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt2_o |=> !dbg_evt2_o);
    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt1_o == '0 && !wr_en) |=> cnt1_o == '0);
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt2_o == $past(cnt2_o) || cnt2_o == $past(cnt2_o) - CNT_W'(1)));
    assert_exc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt2_o |-> exc_en[1]);
    assert_idle_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mask != '0 && !c1_armed_o && !wr_en) |=> cnt1_o == $past(cnt1_o));
    assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_armed_o && !(wr_en && wr_addr == RA_TRIG)) |=> c1_armed_o);
    assert_cfg_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_TRIG) |=> !c1_armed_o);
endmodule

bind dbg_evt_ctr_pair dbg_evt_ctr_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cnt1_o(cnt1_o), .cnt2_o(cnt2_o), .c1_armed_o(c1_armed_o),
    .dbg_evt1_o(dbg_evt1_o), .dbg_evt2_o(dbg_evt2_o),
    .exc_en(exc_en), .trig_mask(trig_mask)
);

// File: tb/dbg_evt_ctr_pair_test.sv
module dbg_evt_ctr_pair_test;
    localparam logic [12:0] E_IAC1 = 13'h0001, E_IAC2 = 13'h0002, E_D1R = 13'h0010,
                            E_EXT1 = 13'h0100, E_ICMP = 13'h0400, E_IRPT = 13'h0800;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] evt = '0;
    logic mw_active = 1'b0, mw_done = 1'b0, mw_abort = 1'b0;
    logic [15:0] cnt1_o, cnt2_o;
    logic c1_armed_o, dbg_evt1_o, dbg_evt2_o;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    typedef struct { logic [15:0] c1; logic [15:0] c2; logic arm; logic p1; logic p2; string tag; } exp_t;
    exp_t q[$];

    // Reference model state, from the requirements
    logic [15:0] m_c1 = '0, m_c2 = '0;
    logic [12:0] m_m1 = '0, m_m2 = '0;
    logic [6:0]  m_trig = '0;
    logic m_x1 = 0, m_x2 = 0, m_arm = 0, m_z1 = 0, m_z2 = 0, m_pd1 = 0, m_pd2 = 0;

    always #5 clk = ~clk;

    dbg_evt_ctr_pair uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt(evt), .mw_active(mw_active), .mw_done(mw_done), .mw_abort(mw_abort),
        .cnt1_o(cnt1_o), .cnt2_o(cnt2_o), .c1_armed_o(c1_armed_o),
        .dbg_evt1_o(dbg_evt1_o), .dbg_evt2_o(dbg_evt2_o)
    );

    // Returns {pending_next, step} for one counter
    function automatic logic [1:0] ctr_eval(logic [12:0] e, logic [12:0] m, logic run, logic pd,
                                           logic ma, logic md, logic mab, logic [15:0] c);
        logic ah, oh, take, st, pn;
        ah = |(e & m & 13'h00FF);
        oh = |(e & m & 13'h1F00);
        take = (ma | md | mab) ? (md & (pd | ah)) : ah;
        st = run & (oh | take) & (c != 0);
        pn = (md | mab) ? 1'b0 : ((ma & run & ah) ? 1'b1 : pd);
        return {pn, st};
    endfunction

    // Driver: one cycle of stimulus plus the expected outcome
    task automatic cyc(input logic [12:0] e, input logic we, input logic [2:0] wa, input logic [31:0] wd,
                       input logic ma, input logic md, input logic mab, input string tag);
        logic [1:0] r1, r2;
        logic ld1, ld2, hit, run1;
        exp_t it;
        @(negedge clk);
        evt = e; wr_en = we; wr_addr = wa; wr_data = wd;
        mw_active = ma; mw_done = md; mw_abort = mab;
        run1 = (m_trig == 0) | m_arm;
        ld1 = we && wa == 3'd3;
        ld2 = we && wa == 3'd4;
        r1 = ctr_eval(e, m_m1, run1, m_pd1, ma, md, mab, m_c1);
        r2 = ctr_eval(e, m_m2, 1'b1, m_pd2, ma, md, mab, m_c2);
        hit = |({m_z2, e[5], e[4], e[2], e[0], e[9], e[8]} & m_trig);
        m_z1 = !ld1 && r1[0] && m_c1 == 16'd1;
        m_z2 = !ld2 && r2[0] && m_c2 == 16'd1;
        m_c1 = ld1 ? wd[15:0] : (r1[0] ? m_c1 - 16'd1 : m_c1);
        m_c2 = ld2 ? wd[15:0] : (r2[0] ? m_c2 - 16'd1 : m_c2);
        m_pd1 = r1[1]; m_pd2 = r2[1];
        m_arm = (we && wa == 3'd2) ? 1'b0 : (m_arm | hit);
        if (we && wa == 3'd0) m_m1 = wd[12:0];
        if (we && wa == 3'd1) m_m2 = wd[12:0];
        if (we && wa == 3'd2) begin m_trig = wd[6:0]; m_x1 = wd[8]; m_x2 = wd[9]; end
        it.c1 = m_c1; it.c2 = m_c2; it.arm = m_arm; it.p1 = m_z1 & m_x1; it.p2 = m_z2 & m_x2; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        cyc('0, 1'b1, a, d, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic ev(input logic [12:0] e, input string tag);
        cyc(e, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic mw(input logic [12:0] e, input logic ma, input logic md, input logic mab, input string tag);
        cyc(e, 1'b0, '0, '0, ma, md, mab, tag);
    endtask

    // Monitor: compare outputs after each edge against the queued item
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (cnt1_o !== it.c1 || cnt2_o !== it.c2 || c1_armed_o !== it.arm ||
                    dbg_evt1_o !== it.p1 || dbg_evt2_o !== it.p2) begin
                    fails++;
                    $display("FAIL %s: actual c1=%0d c2=%0d arm=%b p1=%b p2=%b expected c1=%0d c2=%0d arm=%b p1=%b p2=%b",
                             it.tag, cnt1_o, cnt2_o, c1_armed_o, dbg_evt1_o, dbg_evt2_o,
                             it.c1, it.c2, it.arm, it.p1, it.p2);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        ev('0, "R1 reset state");
        ev(E_ICMP, "R1 masks zero after reset");
        // R2 configuration
        wr(3'd0, 32'(E_IAC1 | E_ICMP), "R2 mask1 write");
        wr(3'd1, 32'(E_D1R), "R2 mask2 write");
        wr(3'd2, 32'h100, "R2 trig/exc write");
        wr(3'd3, 32'd3, "R2 cnt1 load");
        wr(3'd4, 32'd2, "R2 cnt2 load");
        ev(E_IAC2, "R4 unmasked event ignored");
        ev(E_IAC1 | E_ICMP, "R3 two events one step");
        ev(E_IAC1 | E_D1R, "R3 both counters step");
        ev(E_ICMP, "R5 one-to-zero pulse on c1");
        ev(E_D1R, "R6 c2 counts with exception off");
        ev(E_ICMP | E_D1R, "R5 hold at zero");
        cyc(E_ICMP, 1'b1, 3'd3, 32'd5, 1'b0, 1'b0, 1'b0, "R2 load beats decrement");
        // R7 arming by external event
        wr(3'd2, 32'h101, "R7 trigger ext1");
        ev(E_ICMP, "R7 idle while unarmed");
        ev(E_EXT1 | E_ICMP, "R7 trigger cycle not counted");
        ev(E_ICMP, "R7 counts once armed");
        wr(3'd0, 32'(E_IAC1 | E_ICMP | E_IRPT), "R9 armed survives other write");
        ev(E_ICMP, "R9 still armed");
        wr(3'd2, 32'h101, "R9 trigger write disarms");
        ev(E_ICMP, "R9 idle after disarm");
        // R8 chain from counter 2
        wr(3'd2, 32'h040, "R8 chain trigger only");
        wr(3'd4, 32'd1, "R8 load c2");
        ev(E_ICMP, "R8 c1 idle before chain");
        ev(E_D1R, "R8 c2 reaches zero, output quiet");
        ev(E_ICMP, "R8 arm lands, event not counted");
        ev(E_ICMP, "R8 c1 counts after chain");
        // Multi-word accesses
        wr(3'd2, 32'h000, "R10 clear triggers");
        wr(3'd3, 32'd5, "R10 load c1");
        mw(E_IAC1, 1'b1, 1'b0, 1'b0, "R10 deferred in access");
        mw(E_IAC1, 1'b1, 1'b0, 1'b0, "R10 second match deferred");
        mw('0, 1'b0, 1'b1, 1'b0, "R10 one count on completion");
        mw(E_IAC1, 1'b1, 1'b0, 1'b0, "R11 deferred before abort");
        mw(E_IAC1, 1'b0, 1'b0, 1'b1, "R11 abort drops count");
        ev('0, "R11 no late count");
        mw(E_IRPT, 1'b1, 1'b0, 1'b0, "R12 non-address counts in access");
        mw(E_IAC1, 1'b1, 1'b0, 1'b0, "R10 deferred again");
        mw(E_IRPT, 1'b0, 1'b1, 1'b0, "R3 completion plus event one step");
        ev('0, "R3 settle");
        @(negedge clk);
        evt = '0; mw_active = 0; mw_done = 0; mw_abort = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule